// File: doc/BRIEF.md
# Single-Transfer Bus Master with Busy-Low Handshake

This block lets a simple local requester reach on-chip memory through a pipelined address/data bus master port of the AHB kind. The requester presents an address, write data and a transfer size together with a one-cycle pulse on either its read strobe or its write strobe. The block accepts the command, runs exactly one non-sequential single transfer on the bus, and returns the read data. A ready flag toward the requester is high while the block is free, drops for as long as the transfer is in flight, and rises again when the result is available.

A transfer that stalls cannot hang the requester. A cycle counter starts when a command is accepted. If the bus has not completed the transfer within a fixed number of cycles, the block abandons it and frees itself. A read that ends this way returns zero, and an error flag stays set until the next command is accepted.

Top module: `dma_lite_master`

## Requirements
- R1: After reset, `req_ok` is 1, `req_err` is 0, `req_rdata` is all zero and `m_trans` is 2'b00 (idle).
- R2: While a transfer is in its address phase, `m_trans` is 2'b10 (non-sequential) and `m_burst` is 3'b000 (single). `m_addr` carries the request address and `m_write` is 1 for a write. `m_size` is `{1'b0, req_size}`, where `req_size` 2'b00 means byte, 2'b01 means halfword and 2'b10 means word. Outside a transfer, `m_trans` is 2'b00.
- R3: A request is accepted when `req_ok` is 1 and exactly one of `req_rd`/`req_wr` is 1 at a clock edge. `req_ok` is 0 from the next cycle on. The address phase lasts until `m_ready` is sampled high. The data phase then lasts until `m_ready` is sampled high again. `req_ok` is 1 in the cycle after that second edge. With zero wait states, `req_ok` is low for 2 cycles.
- R4: A request with both `req_rd` and `req_wr` at 1 is ignored. A request that arrives while `req_ok` is 0 is also ignored.
- R5: `m_addr`, `m_write` and `m_size` stay unchanged from acceptance until `req_ok` rises again.
- R6: When a transfer has not completed by the 20th clock edge after acceptance, it is ended at that edge. In that case `req_ok` has been low for exactly 20 cycles.
- R7: For a completed read, `req_rdata` holds the `m_rdata` value sampled at the completing edge, from the cycle in which `req_ok` rises. For a write, `m_wdata` carries the request write data during the data phase.
- R8: A read that times out sets `req_rdata` to zero. Any timed-out transfer sets `req_err`, which stays 1 until the next request is accepted and is cleared at that acceptance.
- R9: A write, whether completed or timed out, leaves `req_rdata` unchanged.
- R10: When the completing edge of the data phase is also the 20th edge after acceptance, the transfer counts as completed. The read data is returned and `req_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Request write data |
| req_size | input | 2 | Request size: 00 byte, 01 halfword, 10 word |
| req_rd | input | 1 | One-cycle read strobe |
| req_wr | input | 1 | One-cycle write strobe |
| req_rdata | output | 32 | Returned read data |
| req_ok | output | 1 | High when free, low while busy |
| req_err | output | 1 | Sticky timeout flag |
| m_addr | output | 32 | Bus address |
| m_trans | output | 2 | Bus transfer type |
| m_write | output | 1 | Bus direction, 1 for write |
| m_size | output | 3 | Bus transfer size |
| m_burst | output | 3 | Bus burst type, always single |
| m_wdata | output | 32 | Bus write data |
| m_rdata | input | 32 | Bus read data |
| m_ready | input | 1 | Bus ready |

## Verification
The bus completing the data phase and the watchdog expiring can fall on the same clock edge. The bench sets this up by choosing address and data wait states that add up to exactly the timeout window, so the final ready arrives on the 20th edge after acceptance. In that case the read data must come back, the error flag must stay low and the busy time must be exactly 20 cycles. Neighbouring cases one cycle shorter and well past the window, in either phase, show that the decision really depends on which event comes first.

// File: rtl/dma_lite_pkg.sv
package dma_lite_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_t;

   localparam logic [1:0] TRANS_IDLE   = 2'b00;
   localparam logic [1:0] TRANS_NONSEQ = 2'b10;
   localparam logic [2:0] BURST_SINGLE = 3'b000;

endpackage

// File: rtl/dma_lite_timer.sv
module dma_lite_timer #(
   parameter int LIMIT = 20,
   localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic expire
);

   generate
      if (LIMIT == 0) begin : g_no_timer
         assign expire = 1'b0;
      end else begin : g_timer
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (start)
               cnt <= '0;
            else if (run && cnt != CNT_W'(LIMIT - 1))
               cnt <= cnt + 1'b1;
         end

         assign expire = run && (cnt == CNT_W'(LIMIT - 1));
      end
   endgenerate

endmodule

// File: rtl/dma_lite_seq.sv
module dma_lite_seq
   import dma_lite_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   bus_ready,
   input  logic   expire,
   output phase_t phase,
   output logic   done,
   output logic   abort
);

   phase_t phase_nx;

   assign done  = (phase == PH_DATA) && bus_ready;
   assign abort = expire && !done;

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE: if (start) phase_nx = PH_ADDR;
         PH_ADDR: begin
            if (expire)         phase_nx = PH_IDLE;
            else if (bus_ready) phase_nx = PH_DATA;
         end
         PH_DATA: if (bus_ready || expire) phase_nx = PH_IDLE;
         default: phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nx;
   end

endmodule

// File: rtl/dma_lite_result.sv
module dma_lite_result #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              done,
   input  logic              abort,
   input  logic              is_write,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         if (done && !is_write)
            rdata <= bus_rdata;
         else if (abort && !is_write)
            rdata <= '0;

         if (start)      err <= 1'b0;
         else if (abort) err <= 1'b1;
      end
   end

endmodule

// File: rtl/dma_lite_master.sv
module dma_lite_master
   import dma_lite_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int SIZE_W      = 2,
   parameter int BUS_SIZE_W  = 3,
   parameter int TIMEOUT_CYC = 20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [SIZE_W-1:0]     req_size,
   input  logic                  req_rd,
   input  logic                  req_wr,
   output logic [DATA_W-1:0]     req_rdata,
   output logic                  req_ok,
   output logic                  req_err,
   output logic [ADDR_W-1:0]     m_addr,
   output logic [1:0]            m_trans,
   output logic                  m_write,
   output logic [BUS_SIZE_W-1:0] m_size,
   output logic [2:0]            m_burst,
   output logic [DATA_W-1:0]     m_wdata,
   input  logic [DATA_W-1:0]     m_rdata,
   input  logic                  m_ready
);

   localparam int SIZE_PAD = BUS_SIZE_W - SIZE_W;

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
         $error("DATA_W must be a power of two of at least 8");
      end
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("ADDR_W must be at least 8");
      end
      if (SIZE_PAD < 0) begin : g_bad_size_w
         $error("BUS_SIZE_W must not be narrower than SIZE_W");
      end
      if (TIMEOUT_CYC < 0) begin : g_bad_timeout
         $error("TIMEOUT_CYC must not be negative");
      end
   endgenerate

   phase_t phase;
   logic   start, done, abort, expire, busy;

   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_wdata;
   logic [SIZE_W-1:0] cmd_size;
   logic              cmd_write;

   assign busy  = (phase != PH_IDLE);
   assign start = !busy && (req_rd ^ req_wr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_addr  <= '0;
         cmd_wdata <= '0;
         cmd_size  <= '0;
         cmd_write <= 1'b0;
      end else if (start) begin
         cmd_addr  <= req_addr;
         cmd_wdata <= req_wdata;
         cmd_size  <= req_size;
         cmd_write <= req_wr;
      end
   end

   dma_lite_timer #(
      .LIMIT (TIMEOUT_CYC)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .run    (busy),
      .expire (expire)
   );

   dma_lite_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .bus_ready (m_ready),
      .expire    (expire),
      .phase     (phase),
      .done      (done),
      .abort     (abort)
   );

   dma_lite_result #(
      .DATA_W (DATA_W)
   ) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .done      (done),
      .abort     (abort),
      .is_write  (cmd_write),
      .bus_rdata (m_rdata),
      .rdata     (req_rdata),
      .err       (req_err)
   );

   generate
      if (SIZE_PAD > 0) begin : g_size_pad
         assign m_size = {{SIZE_PAD{1'b0}}, cmd_size};
      end else begin : g_size_direct
         assign m_size = BUS_SIZE_W'(cmd_size);
      end
   endgenerate

   assign req_ok  = !busy;
   assign m_addr  = cmd_addr;
   assign m_write = cmd_write;
   assign m_wdata = cmd_wdata;
   assign m_burst = BURST_SINGLE;
   assign m_trans = (phase == PH_ADDR) ? TRANS_NONSEQ : TRANS_IDLE;

endmodule

// File: rtl/dma_lite_chk.sv
module dma_lite_chk #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int BUS_SIZE_W  = 3,
   parameter int TIMEOUT_CYC = 20,
   localparam int RUN_W      = $clog2(TIMEOUT_CYC + 2) + 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_rd,
   input logic                  req_wr,
   input logic [DATA_W-1:0]     req_rdata,
   input logic                  req_ok,
   input logic                  req_err,
   input logic [ADDR_W-1:0]     m_addr,
   input logic [1:0]            m_trans,
   input logic                  m_write,
   input logic [BUS_SIZE_W-1:0] m_size,
   input logic [2:0]            m_burst
);

   logic [RUN_W-1:0] low_run;

   always_ff @(posedge clk) begin
      if (!rst_n)
         low_run <= '0;
      else if (req_ok)
         low_run <= '0;
      else if (low_run != {RUN_W{1'b1}})
         low_run <= low_run + 1'b1;
   end

   assert_accept_drops_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ok && (req_rd ^ req_wr)) |=> !req_ok);

   assert_both_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ok && req_rd && req_wr) |=> req_ok);

   assert_cmd_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ok && $past(!req_ok)) |-> ($stable(m_addr) && $stable(m_write) && $stable(m_size)));

   assert_single_nonseq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_trans != 2'b00) |-> (m_trans == 2'b10 && m_burst == 3'b000 && !req_ok));

   assert_timeout_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ok |-> (low_run < RUN_W'(TIMEOUT_CYC)));

   assert_err_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_err) |-> $rose(req_ok));

   assert_timeout_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(req_err) && !m_write) |-> (req_rdata == '0));

endmodule

bind dma_lite_master dma_lite_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .BUS_SIZE_W  (BUS_SIZE_W),
   .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_rd    (req_rd),
   .req_wr    (req_wr),
   .req_rdata (req_rdata),
   .req_ok    (req_ok),
   .req_err   (req_err),
   .m_addr    (m_addr),
   .m_trans   (m_trans),
   .m_write   (m_write),
   .m_size    (m_size),
   .m_burst   (m_burst)
);

// File: tb/sim_dma_lite_master.sv
module sim_dma_lite_master;

   localparam int CLK_P   = 10;
   localparam int TMO     = 20;
   localparam int NVEC    = 8;

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] wd;
      logic [1:0]  sz;
      logic [5:0]  aw;
      logic [5:0]  dw;
      logic [31:0] brd;
      logic        poke;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 32'h0000_1000, 32'h0,         2'b10, 6'd0,  6'd0,  32'hA5A5_0001, 1'b0},
      '{1'b1, 32'h0000_2002, 32'h1234_BEEF, 2'b01, 6'd1,  6'd2,  32'h0,         1'b0},
      '{1'b0, 32'h0000_3003, 32'h0,         2'b00, 6'd2,  6'd3,  32'h0000_005A, 1'b1},
      '{1'b0, 32'h0000_4000, 32'h0,         2'b10, 6'd0,  6'd25, 32'hDEAD_DEAD, 1'b0},
      '{1'b1, 32'h0000_5004, 32'h0F0F_0F0F, 2'b10, 6'd0,  6'd0,  32'h0,         1'b0},
      '{1'b0, 32'h0000_6008, 32'h0,         2'b10, 6'd5,  6'd13, 32'hCAFE_F00D, 1'b0},
      '{1'b1, 32'h0000_7000, 32'h5555_AAAA, 2'b10, 6'd30, 6'd0,  32'h0,         1'b1},
      '{1'b0, 32'h0000_800C, 32'h0,         2'b01, 6'd3,  6'd14, 32'h0000_7E57, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] req_addr, req_wdata, req_rdata, m_addr, m_wdata, m_rdata;
   logic [1:0]  req_size, m_trans;
   logic        req_rd, req_wr, req_ok, req_err, m_write, m_ready;
   logic [2:0]  m_size, m_burst;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] exp_rd = '0;
   bit summary_done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dma_lite_master u0 (
      .clk(clk), .rst_n(rst_n),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
      .req_rd(req_rd), .req_wr(req_wr), .req_rdata(req_rdata),
      .req_ok(req_ok), .req_err(req_err),
      .m_addr(m_addr), .m_trans(m_trans), .m_write(m_write),
      .m_size(m_size), .m_burst(m_burst), .m_wdata(m_wdata),
      .m_rdata(m_rdata), .m_ready(m_ready)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic run_one(input vec_t v);
      int busy;
      int ab;
      int exp_busy;
      bit exp_err;
      ab       = int'(v.aw) + int'(v.dw) + 2;
      exp_busy = (ab <= TMO) ? ab : TMO;
      exp_err  = (ab > TMO);

      // drive request for one cycle
      req_addr  = v.addr;
      req_wdata = v.wd;
      req_size  = v.sz;
      req_wr    = v.wr;
      req_rd    = !v.wr;
      @(posedge clk);
      @(negedge clk);
      req_rd = 1'b0;
      req_wr = 1'b0;

      check("R3", "ok low after accept", {31'b0, req_ok}, 32'd0);
      check("R2", "trans nonseq", {30'b0, m_trans}, 32'h2);
      check("R2", "burst single", {29'b0, m_burst}, 32'h0);
      check("R2", "addr", m_addr, v.addr);
      check("R2", "write", {31'b0, m_write}, {31'b0, v.wr});
      check("R2", "size", {29'b0, m_size}, {30'b0, v.sz});

      busy = 0;
      while (busy < 40) begin
         if (req_ok) break;
         m_ready = (busy == int'(v.aw)) || (busy == int'(v.aw) + int'(v.dw) + 1);
         m_rdata = (busy > int'(v.aw)) ? v.brd : 32'hFFFF_FFFF;
         if (v.wr && busy == int'(v.aw) + 1)
            check("R7", "wdata in data phase", m_wdata, v.wd);
         if (v.poke && busy == 0) begin
            req_addr = ~v.addr;
            req_rd   = 1'b1;
         end
         @(posedge clk);
         @(negedge clk);
         req_rd = 1'b0;
         busy++;
      end
      m_ready = 1'b1;

      if (!v.wr) exp_rd = exp_err ? 32'h0 : v.brd;

      check(exp_err ? "R6" : (ab == TMO ? "R10" : "R3"), "busy cycles", busy, exp_busy);
      check(exp_err ? "R8" : (ab == TMO ? "R10" : "R7"), "rdata", req_rdata, exp_rd);
      check(exp_err ? "R8" : "R10", "err flag", {31'b0, req_err}, {31'b0, exp_err});
      check(v.poke ? "R4" : "R5", "addr held", m_addr, v.addr);
      check("R2", "trans idle after", {30'b0, m_trans}, 32'h0);
      if (v.wr) check("R9", "write keeps rdata", req_rdata, exp_rd);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      rst_n     = 1'b0;
      req_addr  = '0;
      req_wdata = '0;
      req_size  = '0;
      req_rd    = 1'b0;
      req_wr    = 1'b0;
      m_rdata   = '0;
      m_ready   = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1", "ok", {31'b0, req_ok}, 32'd1);
      check("R1", "err", {31'b0, req_err}, 32'd0);
      check("R1", "rdata", req_rdata, 32'd0);
      check("R1", "trans", {30'b0, m_trans}, 32'd0);

      // R4 both strobes together are ignored
      req_addr = 32'h0000_9990;
      req_rd   = 1'b1;
      req_wr   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_rd = 1'b0;
      req_wr = 1'b0;
      check("R4", "ok after both strobes", {31'b0, req_ok}, 32'd1);
      check("R4", "trans after both strobes", {30'b0, m_trans}, 32'd0);

      for (int i = 0; i < NVEC; i++) begin
         run_one(VEC[i]);
         @(negedge clk);
      end

      // R8 error cleared at next acceptance, even before completion
      run_one('{1'b0, 32'h0000_A000, 32'h0, 2'b10, 6'd40, 6'd0, 32'h0, 1'b0});
      req_addr = 32'h0000_B000;
      req_rd   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_rd = 1'b0;
      check("R8", "err cleared on accept", {31'b0, req_err}, 32'd0);
      m_ready = 1'b1;
      m_rdata = 32'h1357_2468;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check("R7", "zero-wait read data", req_rdata, 32'h1357_2468);
      check("R3", "zero-wait ok back", {31'b0, req_ok}, 32'd1);

      finish_run();
   end

endmodule